// File: doc/BRIEF.md
# Serial Line Transceiver Power-Down Controller

This block is the clocked control core of a multi-channel serial line interface. It decides when the charge pump is enabled, when the line transmitters drive, when the standard (inverting) receiver outputs are enabled and whether the monitor receivers are active. It also produces an active-low line-activity flag, `invalid_n`. The analog comparators, the charge pump and the line drivers are outside the block. The block sees them only as one "level valid" bit per receiver and a "pump ready" bit. Every control input passes through a two-flop synchronizer before it is used.

There are two control variants, chosen by a parameter. In the two-pin variant, a dominant active-low force-off pin and a force-on pin together choose between manual power-down, always-on and automatic sleep. In automatic sleep the block powers down when `invalid_n` falls and wakes when a valid level returns. In the single-pin variant, the force-off pin works as a plain active-low shutdown. That shutdown gates only the pump and the transmitters, and the receiver outputs follow a separate active-low enable. The `invalid_n` timing is asymmetric: it falls only after a long run of all-idle inputs and rises after a short run with any input valid.

Top module: `line_pwr_ctrl`

## Requirements
- R1: While reset is held and right after it, `pump_en`, `tx_oe`, `rx_oe` and `invalid_n` are 0 and `mon_oe` is 1.
- R2: `invalid_n` falls at the clock edge `INV_SET_CYC + SYNC_STAGES` cycles after every `line_valid` bit goes to 0. Any synchronized valid cycle in between restarts that count.
- R3: When `invalid_n` is 0 and any `line_valid` bit goes to 1 and stays there, `invalid_n` rises at the edge `INV_CLR_CYC + SYNC_STAGES` cycles later.
- R4: `invalid_n` is computed in every mode: forced off, forced on, automatic and single-pin shutdown.
- R5: A low `force_off_n` turns off `pump_en` and `tx_oe` one cycle after it is synchronized, whatever the state of `force_on` and `invalid_n`.
- R6: Two-pin variant with `force_on`=0 and `force_off_n`=1 (automatic mode): a low `invalid_n` turns the pump and transmitters off, and a rising `invalid_n` turns the pump back on.
- R7: Two-pin variant with `force_on`=1 and `force_off_n`=1: the pump stays on even while `invalid_n` is 0.
- R8: `tx_oe` rises only when the pump is enabled and the synchronized `pump_ready` is 1. It falls again if `pump_ready` drops.
- R9: Two-pin variant: `rx_oe` is 0 only during manual power-down (`force_off_n`=0). It stays 1 during automatic power-down, and `rx_en_n` has no effect.
- R10: `mon_oe` is 1 in every mode.
- R11: Single-pin variant (`SINGLE_PIN`=1): `force_off_n` acts as shutdown for the pump and transmitters only, `force_on` is ignored and there is no automatic sleep. `rx_oe` equals the inverse of `rx_en_n` even during shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_off_n | input | 1 | Two-pin: dominant manual power-down (low). Single-pin: shutdown (low) |
| force_on | input | 1 | Two-pin: keep powered, bypassing automatic sleep. Ignored in single-pin |
| rx_en_n | input | 1 | Single-pin: active-low standard receiver enable. Ignored in two-pin |
| line_valid | input | NUM_RX | Per-receiver valid line level flag from the comparators |
| pump_ready | input | 1 | Charge pump has reached its operating level |
| pump_en | output | 1 | Charge pump enable |
| tx_oe | output | 1 | Transmitter output enable (0 = high impedance) |
| rx_oe | output | 1 | Standard receiver output enable |
| mon_oe | output | 1 | Monitor receiver enable |
| invalid_n | output | 1 | Low when no receiver has shown a valid level for the persistence time |

## Verification
The bench builds two instances side by side, one of each control variant, with `INV_SET_CYC`=40 and `INV_CLR_CYC`=4. These short windows let it probe the exact edge at which `invalid_n` falls and rises, one cycle before and at the edge. They also bring the restart of the persistence count by a single-cycle valid pulse within a few dozen cycles. Because both variants see the same pins, each mode transition also shows how the other variant ignores the pins it does not use.

// File: rtl/line_pwr_pkg.sv
package line_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_PUMP = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/line_pwr_sync.sv
module line_pwr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/line_pwr_inv_timer.sv
module line_pwr_inv_timer #(
  parameter int SET_CYC = 2000,
  parameter int CLR_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_valid,
  output logic invalid_n
);
  localparam int MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          against;

  // the counter runs while the inputs disagree with the current flag value
  assign against = invalid_n ? !any_valid : any_valid;
  assign limit   = invalid_n ? CW'(SET_CYC - 1) : CW'(CLR_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      invalid_n <= 1'b0;
      cnt_q     <= '0;
    end else if (against) begin
      if (cnt_q == limit) begin
        invalid_n <= ~invalid_n;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/line_pwr_fsm.sv
module line_pwr_fsm
  import line_pwr_pkg::*;
#(
  parameter bit SINGLE_PIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_n_s,
  input  logic on_s,
  input  logic rxen_n_s,
  input  logic invalid_n,
  input  logic ready_s,
  output logic pump_en,
  output logic tx_oe,
  output logic rx_oe
);
  pwr_state_e state_q, state_d;
  logic       want_on;
  logic       rx_want;

  if (SINGLE_PIN) begin : g_single
    logic unused_sp;
    assign unused_sp = on_s ^ invalid_n;
    assign want_on   = off_n_s;
    assign rx_want   = !rxen_n_s;
  end else begin : g_dual
    logic unused_dp;
    assign unused_dp = rxen_n_s;
    assign want_on   = off_n_s && (on_s || invalid_n);
    assign rx_want   = off_n_s;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_OFF:  if (want_on) state_d = PWR_PUMP;
      PWR_PUMP: begin
        if (!want_on)     state_d = PWR_OFF;
        else if (ready_s) state_d = PWR_ON;
      end
      PWR_ON: begin
        if (!want_on)      state_d = PWR_OFF;
        else if (!ready_s) state_d = PWR_PUMP;
      end
      default: state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_OFF;
      rx_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      rx_oe   <= rx_want;
    end
  end

  assign pump_en = (state_q != PWR_OFF);
  assign tx_oe   = (state_q == PWR_ON);
endmodule

// File: rtl/line_pwr_ctrl.sv
module line_pwr_ctrl #(
  parameter int NUM_RX      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int INV_SET_CYC = 2000,
  parameter int INV_CLR_CYC = 100,
  parameter bit SINGLE_PIN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_off_n,
  input  logic              force_on,
  input  logic              rx_en_n,
  input  logic [NUM_RX-1:0] line_valid,
  input  logic              pump_ready,
  output logic              pump_en,
  output logic              tx_oe,
  output logic              rx_oe,
  output logic              mon_oe,
  output logic              invalid_n
);
  localparam int LW = NUM_RX + 1;

  logic [2:0]    ctrl_s;
  logic [LW-1:0] lvl_s;
  logic          off_s, on_s, rxen_n_s, rdy_s, any_valid;

  // control pins reset to: off asserted, force-on clear, receivers disabled
  line_pwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rx_en_n, force_on, force_off_n}),
    .q     (ctrl_s)
  );

  line_pwr_sync #(.W(LW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pump_ready, line_valid}),
    .q     (lvl_s)
  );

  assign off_s     = ctrl_s[0];
  assign on_s      = ctrl_s[1];
  assign rxen_n_s  = ctrl_s[2];
  assign rdy_s     = lvl_s[NUM_RX];
  assign any_valid = |lvl_s[NUM_RX-1:0];

  line_pwr_inv_timer #(.SET_CYC(INV_SET_CYC), .CLR_CYC(INV_CLR_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_valid (any_valid),
    .invalid_n (invalid_n)
  );

  line_pwr_fsm #(.SINGLE_PIN(SINGLE_PIN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_n_s   (off_s),
    .on_s      (on_s),
    .rxen_n_s  (rxen_n_s),
    .invalid_n (invalid_n),
    .ready_s   (rdy_s),
    .pump_en   (pump_en),
    .tx_oe     (tx_oe),
    .rx_oe     (rx_oe)
  );

  assign mon_oe = 1'b1;
endmodule

// File: rtl/line_pwr_ctrl_chk.sv
module line_pwr_ctrl_chk #(
  parameter bit SINGLE_PIN = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic off_s,
  input logic on_s,
  input logic rxen_n_s,
  input logic any_valid,
  input logic rdy_s,
  input logic pump_en,
  input logic tx_oe,
  input logic rx_oe,
  input logic invalid_n
);
  a_r2_fall_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invalid_n) |-> !$past(any_valid));

  a_r3_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invalid_n) |-> $past(any_valid));

  a_r5_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    !off_s |=> (!pump_en && !tx_oe));

  a_r8_tx_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> ($past(rdy_s) && $past(pump_en)));

  a_r8_tx_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> pump_en);

  if (SINGLE_PIN) begin : g_single
    logic unused_c;
    assign unused_c = on_s;
    a_r11_rx_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_oe == !$past(rxen_n_s)));
    a_r11_no_auto_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      off_s |=> pump_en);
  end else begin : g_dual
    logic unused_c;
    assign unused_c = rxen_n_s;
    a_r6_auto_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (off_s && !on_s && !invalid_n) |=> !pump_en);
    a_r7_force_on_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (off_s && on_s) |=> pump_en);
    a_r9_rx_follows_off: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_oe == $past(off_s)));
  end
endmodule

bind line_pwr_ctrl line_pwr_ctrl_chk #(.SINGLE_PIN(SINGLE_PIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .off_s     (off_s),
  .on_s      (on_s),
  .rxen_n_s  (rxen_n_s),
  .any_valid (any_valid),
  .rdy_s     (rdy_s),
  .pump_en   (pump_en),
  .tx_oe     (tx_oe),
  .rx_oe     (rx_oe),
  .invalid_n (invalid_n)
);

// File: tb/line_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_pwr_ctrl_tb_top;
  localparam int NRX = 5;
  localparam int SET = 40;
  localparam int CLR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_off_n = 1'b1;
  logic force_on = 1'b0;
  logic rx_en_n = 1'b0;
  logic [NRX-1:0] line_valid = '0;
  logic pump_ready = 1'b0;

  logic d_pump, d_tx, d_rx, d_mon, d_inv;
  logic s_pump, s_tx, s_rx, s_mon, s_inv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_pwr_ctrl #(.NUM_RX(NRX), .SYNC_STAGES(2), .INV_SET_CYC(SET),
                  .INV_CLR_CYC(CLR), .SINGLE_PIN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_off_n(force_off_n), .force_on(force_on),
    .rx_en_n(rx_en_n), .line_valid(line_valid), .pump_ready(pump_ready),
    .pump_en(d_pump), .tx_oe(d_tx), .rx_oe(d_rx), .mon_oe(d_mon), .invalid_n(d_inv)
  );

  line_pwr_ctrl #(.NUM_RX(NRX), .SYNC_STAGES(2), .INV_SET_CYC(SET),
                  .INV_CLR_CYC(CLR), .SINGLE_PIN(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .force_off_n(force_off_n), .force_on(force_on),
    .rx_en_n(rx_en_n), .line_valid(line_valid), .pump_ready(pump_ready),
    .pump_en(s_pump), .tx_oe(s_tx), .rx_oe(s_rx), .mon_oe(s_mon), .invalid_n(s_inv)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 two-pin pump_en", d_pump, 1'b0);
    chk("R1 two-pin tx_oe", d_tx, 1'b0);
    chk("R1 two-pin rx_oe", d_rx, 1'b0);
    chk("R1 two-pin invalid_n", d_inv, 1'b0);
    chk("R1 mon_oe", d_mon, 1'b1);
    chk("R1 single-pin pump_en", s_pump, 1'b0);
    chk("R1 single-pin invalid_n", s_inv, 1'b0);
    rst_n = 1'b1;
    tick(10);
    chk("R6 auto asleep with idle lines", d_pump, 1'b0);
    chk("R6 auto tx off with idle lines", d_tx, 1'b0);
    chk("R9 rx on in auto power-down", d_rx, 1'b1);
    chk("R11 single-pin pump on without valid lines", s_pump, 1'b1);
    chk("R8 single-pin tx waits for ready", s_tx, 1'b0);
    chk("R11 single-pin rx follows enable", s_rx, 1'b1);
  endtask

  task automatic t_clear_timing();
    line_valid[2] = 1'b1;
    tick(CLR + 1);
    chk("R3 invalid_n still low one cycle early", d_inv, 1'b0);
    tick(1);
    chk("R3 invalid_n rises on time", d_inv, 1'b1);
    chk("R4 single-pin invalid_n rises too", s_inv, 1'b1);
    tick(2);
    chk("R6 auto wake pump_en", d_pump, 1'b1);
    chk("R8 tx off before ready", d_tx, 1'b0);
  endtask

  task automatic t_ready();
    pump_ready = 1'b1;
    tick(4);
    chk("R8 tx on after ready", d_tx, 1'b1);
    chk("R8 single-pin tx on after ready", s_tx, 1'b1);
    pump_ready = 1'b0;
    tick(4);
    chk("R8 tx drops with ready", d_tx, 1'b0);
    chk("R8 pump kept while ready low", d_pump, 1'b1);
    pump_ready = 1'b1;
    tick(4);
    chk("R8 tx back on", d_tx, 1'b1);
  endtask

  task automatic t_set_timing();
    line_valid = '0;
    tick(SET + 1);
    chk("R2 invalid_n still high one cycle early", d_inv, 1'b1);
    tick(1);
    chk("R2 invalid_n falls on time", d_inv, 1'b0);
    tick(2);
    chk("R6 auto sleep pump off", d_pump, 1'b0);
    chk("R6 auto sleep tx off", d_tx, 1'b0);
    chk("R9 rx stays on in auto sleep", d_rx, 1'b1);
    chk("R11 single-pin stays powered", s_pump, 1'b1);
  endtask

  task automatic t_restart();
    line_valid = 5'b00001;
    tick(CLR + 10);
    chk("R3 invalid_n high before restart test", d_inv, 1'b1);
    line_valid = '0;
    tick(20);
    line_valid[4] = 1'b1;
    tick(1);
    line_valid[4] = 1'b0;
    tick(24);
    chk("R2 pulse restarted the idle count", d_inv, 1'b1);
    tick(30);
    chk("R2 invalid_n falls after restarted count", d_inv, 1'b0);
  endtask

  task automatic t_force_on();
    force_on = 1'b1;
    tick(4);
    chk("R7 force-on powers pump with idle lines", d_pump, 1'b1);
    tick(4);
    chk("R7 force-on enables tx", d_tx, 1'b1);
    chk("R4 invalid_n still low when forced on", d_inv, 1'b0);
  endtask

  task automatic t_force_off();
    force_off_n = 1'b0;
    tick(4);
    chk("R5 force-off beats force-on pump", d_pump, 1'b0);
    chk("R5 force-off tx", d_tx, 1'b0);
    chk("R9 rx off in manual power-down", d_rx, 1'b0);
    chk("R11 shutdown pump off", s_pump, 1'b0);
    chk("R11 shutdown tx off", s_tx, 1'b0);
    chk("R11 rx on during shutdown", s_rx, 1'b1);
    chk("R10 mon_oe in power-down", d_mon, 1'b1);
    chk("R10 single-pin mon_oe in shutdown", s_mon, 1'b1);
    line_valid[1] = 1'b1;
    tick(CLR + 3);
    chk("R4 invalid_n computed while forced off", d_inv, 1'b1);
    chk("R4 single-pin invalid_n in shutdown", s_inv, 1'b1);
  endtask

  task automatic t_rx_enable();
    rx_en_n = 1'b1;
    tick(4);
    chk("R11 rx disabled in shutdown by enable", s_rx, 1'b0);
    force_off_n = 1'b1;
    tick(4);
    chk("R9 rx_en_n ignored by two-pin", d_rx, 1'b1);
    chk("R11 rx stays disabled out of shutdown", s_rx, 1'b0);
    chk("R11 pump back on after shutdown", s_pump, 1'b1);
    rx_en_n = 1'b0;
    tick(4);
    chk("R11 rx re-enabled", s_rx, 1'b1);
  endtask

  initial begin
    t_reset();
    t_clear_timing();
    t_ready();
    t_set_timing();
    t_restart();
    t_force_on();
    t_force_off();
    t_rx_enable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule